// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 16-bit words. It accepts one request at a time on a valid/ready handshake. A request is a read or a write of the whole word, or of a single byte. The block turns each request into a sequence of active-low controls on the memory pins: chip select, write enable, output enable and one control per byte lane.

The shared data bus is split at the block edge into three signals: an outgoing value, an incoming value, and a drive-enable that the pad logic uses. The write pulse and the read pulse each have their own programmable length. The block holds the address and the lane controls for the whole transfer. It frames every write pulse with one setup clock before it and one hold clock after it.

Read data is captured at the end of the read pulse and returned with a one-cycle strobe. The memory needs no clock and no refresh, so the controller only ever issues cycles that a request asked for.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and between transfers, chip select, write enable, output enable and both lane controls are high, the data drive-enable is low and `req_ready_o` is high.
- R2: Byte enable bit 0 selects lane control bit 0, which covers data bits 7:0. Bit 1 selects lane control bit 1, which covers bits 15:8. A request with both enable bits low is treated as a full-word transfer.
- R3: Write enable is low only while chip select and at least one lane control are low. The address does not change while chip select is low.
- R4: Write enable falls no earlier than one clock after chip select went low. Chip select stays low for the clock in which write enable returns high.
- R5: A write holds write enable low for max(wr_wait,1) clocks. Ready returns max(wr_wait,1)+2 clocks after the accepting edge.
- R6: A read holds output enable low, with write enable high, for max(rd_wait,1) clocks.
- R7: Read data is sampled on the edge that ends the read pulse. It is presented with `rsp_valid_o` high for exactly one clock, and a lane that was not selected returns zero.
- R8: The data drive-enable is never high while output enable is low. Before the bus is driven after a read, there is at least one clock with both sides released.
- R9: The wait counts are taken when the transfer starts. Later changes to `rd_wait_i` or `wr_wait_i` do not alter a transfer already running.
- R10: During a transfer, `mem_addr_o` carries the 19-bit word address of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_be_i | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata_i | input | 16 | Write data |
| rd_wait_i | input | 4 | Read pulse length in clocks (0 taken as 1) |
| wr_wait_i | input | 4 | Write pulse length in clocks (0 taken as 1) |
| rsp_valid_o | output | 1 | One-clock read data strobe |
| rsp_rdata_o | output | 16 | Read data, unselected lane zero |
| mem_addr_o | output | 19 | Memory word address |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_lane_no | output | 2 | Byte lane controls, active low |
| mem_dq_o | output | 16 | Data driven to the bus |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 16 | Data sampled from the bus |

## Verification
A write is accepted on one edge. Its setup clock follows, then the write pulse of max(wr_wait,1) clocks, then one hold clock, so ready is due max(wr_wait,1)+2 clocks after acceptance. A read shows output enable low for max(rd_wait,1) clocks, and its strobe and data are due in the clock right after the last low clock. The bench samples on the falling edge. It counts low clocks of each control from the clock after acceptance until ready or the strobe returns, and compares those counts and the data against values computed from the wait setting and a lane-aware memory model. The wait inputs are overwritten right after acceptance, and the counts must still match the values taken at the start.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctrl_st_e;
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] len_i,
  output logic              done_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == WAIT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] lanes_o,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o
);
  assign lanes_o = (be_i == '0) ? '1 : be_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata_o[g*LANE_W +: LANE_W] = mask_i[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW     = 19,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int WAIT_W = 4,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [WAIT_W-1:0] rd_wait_i,
  input  logic [WAIT_W-1:0] wr_wait_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_lane_no,
  output logic [DW-1:0]     mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DW-1:0]     mem_dq_i
);
  ctrl_st_e          st_q, st_d;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, rdata_q, rdata_m;
  logic [LANES-1:0]  lanes_q, lanes_m;
  logic [WAIT_W-1:0] wr_wait_q, cnt_len;
  logic              rsp_q, accept, cnt_load, cnt_done;

  assign accept = req_valid_i && (st_q == ST_IDLE);

  sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_map (
    .be_i    (req_be_i),
    .lanes_o (lanes_m),
    .mask_i  (lanes_q),
    .dq_i    (mem_dq_i),
    .rdata_o (rdata_m)
  );

  // read pulse loads at accept, write pulse loads in the setup clock
  assign cnt_load = (accept && !req_write_i) || (st_q == ST_WSETUP);
  assign cnt_len  = (st_q == ST_WSETUP) ? wr_wait_q : rd_wait_i;

  sram_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .len_i  (cnt_len),
    .done_o (cnt_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = req_write_i ? ST_WSETUP : ST_RD;
      ST_RD:     if (cnt_done) st_d = ST_IDLE;
      ST_WSETUP: st_d = ST_WPULSE;
      ST_WPULSE: if (cnt_done) st_d = ST_WHOLD;
      ST_WHOLD:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      lanes_q   <= '0;
      wr_wait_q <= '0;
      rdata_q   <= '0;
      rsp_q     <= 1'b0;
    end else begin
      st_q  <= st_d;
      rsp_q <= (st_q == ST_RD) && cnt_done;
      if (accept) begin
        addr_q    <= req_addr_i;
        wdata_q   <= req_wdata_i;
        lanes_q   <= lanes_m;
        wr_wait_q <= wr_wait_i;
      end
      if ((st_q == ST_RD) && cnt_done) rdata_q <= rdata_m;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign mem_addr_o  = addr_q;
  assign mem_cs_no   = (st_q == ST_IDLE);
  assign mem_lane_no = (st_q == ST_IDLE) ? '1 : ~lanes_q;
  assign mem_we_no   = (st_q != ST_WPULSE);
  assign mem_oe_no   = (st_q != ST_RD);
  assign mem_dq_oe_o = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
  assign mem_dq_o    = wdata_q;

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_no && mem_we_no && mem_oe_no && !mem_dq_oe_o && (&mem_lane_no)));
  a_r3_we_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && !(&mem_lane_no)));
  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && !$past(mem_cs_no)) |-> $stable(mem_addr_o));
  a_r4_we_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> !$past(mem_cs_no));
  a_r4_we_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> !mem_cs_no);
  a_r7_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r8_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));
  a_r8_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no));
endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [18:0] req_addr_i = '0;
  logic [1:0]  req_be_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [3:0]  rd_wait_i = '0, wr_wait_i = '0;
  logic        req_ready_o, rsp_valid_o, mem_cs_no, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [15:0] rsp_rdata_o, mem_dq_o, mem_dq_i;
  logic [18:0] mem_addr_o;
  logic [1:0]  mem_lane_no;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] ram [64];
  logic [15:0] exp_ram [64];

  always #4 clk_i = ~clk_i;

  sram_lane_ctrl u_sram_lane_ctrl (.*);

  // memory model: drives only selected lanes while reading, junk elsewhere
  always_comb begin
    mem_dq_i = 16'hA5A5;
    if (!mem_cs_no && !mem_oe_no && mem_we_no) begin
      if (!mem_lane_no[0]) mem_dq_i[7:0]  = ram[mem_addr_o[5:0]][7:0];
      if (!mem_lane_no[1]) mem_dq_i[15:8] = ram[mem_addr_o[5:0]][15:8];
    end
  end

  always @(posedge clk_i)
    if (!mem_cs_no && !mem_we_no) begin
      if (!mem_lane_no[0]) ram[mem_addr_o[5:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_lane_no[1]) ram[mem_addr_o[5:0]][15:8] <= mem_dq_o[15:8];
    end

  // pin protocol monitor, sampled away from the active edge
  int mon_r3 = 0, mon_r4 = 0, mon_r8 = 0;
  logic p_we = 1'b1, p_cs = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  logic [18:0] p_addr = '0;
  always @(negedge clk_i) if (rst_ni) begin
    if (!mem_we_no && (mem_cs_no || (&mem_lane_no))) mon_r3++;
    if (!mem_cs_no && !p_cs && mem_addr_o != p_addr) mon_r3++;
    if (!mem_we_no && p_we && p_cs) mon_r4++;
    if (mem_we_no && !p_we && mem_cs_no) mon_r4++;
    if (mem_dq_oe_o && !mem_oe_no) mon_r8++;
    if (mem_dq_oe_o && !p_dqoe && !p_oe) mon_r8++;
    p_we = mem_we_no; p_cs = mem_cs_no; p_oe = mem_oe_no;
    p_dqoe = mem_dq_oe_o; p_addr = mem_addr_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] w);
    return (w == 0) ? 1 : int'(w);
  endfunction

  task automatic do_write(input logic [18:0] a, input logic [1:0] be, input logic [15:0] d,
                          input logic [3:0] w);
    int we_lo = 0, busy = 0;
    bit addr_ok = 1'b1;
    logic [1:0] ln = (be == 2'b00) ? 2'b11 : be;
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_be_i = be;
    req_wdata_i = d; wr_wait_i = w;
    @(negedge clk_i);
    req_valid_i = 1'b0; wr_wait_i = ~w; // R9: late change must not matter
    chk(mem_lane_no == ~ln, "R2 write lanes", mem_lane_no, ~ln);
    while (!req_ready_o && busy < 40) begin
      if (!mem_we_no) we_lo++;
      if (mem_addr_o != a) addr_ok = 1'b0;
      busy++;
      @(negedge clk_i);
    end
    chk(we_lo == eff(w), "R5 R9 write pulse", we_lo, eff(w));
    chk(busy == eff(w) + 2, "R5 ready return", busy, eff(w) + 2);
    chk(addr_ok, "R10 write address", 0, 1);
    if (ln[0]) exp_ram[a[5:0]][7:0]  = d[7:0];
    if (ln[1]) exp_ram[a[5:0]][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [18:0] a, input logic [1:0] be, input logic [3:0] w);
    int oe_lo = 0, busy = 0;
    bit we_ok = 1'b1, addr_ok = 1'b1;
    logic [1:0] ln = (be == 2'b00) ? 2'b11 : be;
    logic [15:0] e = exp_ram[a[5:0]] & {{8{ln[1]}}, {8{ln[0]}}};
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a; req_be_i = be; rd_wait_i = w;
    @(negedge clk_i);
    req_valid_i = 1'b0; rd_wait_i = ~w;
    chk(mem_lane_no == ~ln, "R2 read lanes", mem_lane_no, ~ln);
    while (!rsp_valid_o && busy < 40) begin
      if (!mem_oe_no) oe_lo++;
      if (!mem_we_no) we_ok = 1'b0;
      if (mem_addr_o != a) addr_ok = 1'b0;
      busy++;
      @(negedge clk_i);
    end
    chk(oe_lo == eff(w) && we_ok, "R6 R9 read pulse", oe_lo, eff(w));
    chk(addr_ok, "R10 read address", 0, 1);
    chk(rsp_rdata_o == e, "R7 read data", rsp_rdata_o, e);
    chk(req_ready_o && mem_oe_no, "R1 idle after read", req_ready_o, 1);
    @(negedge clk_i);
    chk(!rsp_valid_o, "R7 strobe one clock", rsp_valid_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin ram[i] = 16'h0; exp_ram[i] = 16'h0; end
    repeat (3) @(negedge clk_i);
    chk(mem_cs_no && mem_we_no && mem_oe_no && mem_lane_no == 2'b11 && !mem_dq_oe_o
        && !rsp_valid_o, "R1 reset state", {mem_cs_no, mem_we_no, mem_oe_no, mem_dq_oe_o}, 4'b1110);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o, "R1 ready after reset", req_ready_o, 1);
    for (int w = 0; w < 16; w++) begin
      logic [18:0] a  = {13'(w * 3 + 1), 6'(w)};
      logic [15:0] d1 = 16'(w * 16'h0911 + 16'h3C5A);
      logic [15:0] d2 = {d1[7:0], d1[15:8]} ^ 16'h5A5A;
      logic [1:0]  bl = (w % 2 == 0) ? 2'b01 : 2'b10;
      do_write(a, 2'b11, d1, 4'(w));
      do_read(a, 2'b11, 4'(w));
      do_write(a, bl, d2, 4'(15 - w));
      do_read(a, 2'b11, 4'(15 - w));
      do_read(a, ~bl, 4'(w));
      do_read(a, bl, 4'(w));
      do_write(a ^ 19'h20, 2'b00, d2, 4'(w));
      do_read(a ^ 19'h20, 2'b00, 4'(w));
    end
    chk(mon_r3 == 0, "R3 write framing", mon_r3, 0);
    chk(mon_r4 == 0, "R4 setup and hold", mon_r4, 0);
    chk(mon_r8 == 0, "R8 bus turnaround", mon_r8, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule